// File: doc/BRIEF.md
# Modulator Control Register Receiver

This block is a write-mostly two-wire serial slave that configures a multi-standard TV RF modulator. A host addresses the slave, then streams data bytes that the block pairs into 16-bit words. The top bit of every word decides its destination: a clear bit sends the word to the frequency register, a set bit sends it to the control register or, when it comes straight after a control word in the same transaction, to one of two option registers. The four registers drive the modulator through parallel outputs, and a standby indication is decoded from three control bits.

A read transaction returns one status byte assembled from three status inputs. SCL and SDA are sampled through a synchronizer on a system clock at least eight times faster than SCL. SDA is driven open-drain: the block only ever asks for the line to be pulled low.

Top module: `modctl_i2c_slave`

## Requirements
- R1: The slave answers only the 7-bit address {1,1,0,0,1,addr_sel,1} (write byte 0xCA or 0xCE, read byte 0xCB or 0xCF, last bit 0 = write, 1 = read); it pulls SDA low during the ninth clock of the address byte and of each accepted data byte, and otherwise leaves SDA released; SDA drive changes only while SCL is low.
- R2: Data bytes, MSB first on rising SCL, are paired in arrival order into words {first, second}; an unpaired final byte of a write is discarded and never pairs with a byte of a later transaction.
- R3: A word with bit 15 = 0 goes to the frequency register and one with bit 15 = 1 to the control-type path; the two may come in either order or in separate transactions.
- R4: A control-type word that directly follows the control word in the same transaction loads option register 1, and the next one loads option register 2; a frequency word, a START or a STOP ends that chain, so a later control-type word loads the control register.
- R5: At most eight data bytes per transaction are acknowledged and used; a ninth and later bytes get no acknowledge and change nothing.
- R6: A completed word is visible on its register output before the acknowledge clock of its second byte ends.
- R7: The divider value N sits in frequency bits 13:2 (bit 14 test-pattern enable, bits 1:0 test-mode bits); a frequency word with N = 0 is not stored.
- R8: Standby is control bits 13, 6 and 5 all 1; in standby, frequency and option writes are not stored while control writes still are.
- R9: With control bit 6 = 1 (oscillator off) option writes are not stored.
- R10: A read returns one byte {00000, status_in[2:0]}, MSB first, each bit changing after a falling SCL.
- R11: After reset the control output is 0x8008 (sound select 01 in bits 4:3), the frequency output 0x24F4 (N = 2365), option 1 0x8000, option 2 0x8001 (clip level 01 in bits 1:0), and standby is 0.
- R12: A START arriving in the middle of a byte abandons the partly received word without storing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel | input | 1 | Strap selecting address bit 1 |
| status_in | input | 3 | Bit 2 too-high/too-low, bit 1 VCO low/high, bit 0 out-of-range |
| ctrl_word | output | 16 | Control register |
| freq_word | output | 16 | Frequency register |
| opt1_word | output | 16 | Option register 1 |
| opt2_word | output | 16 | Option register 2 |
| standby | output | 1 | Standby decoded from control register |

## Verification
Every pin change reaches the byte engine three clocks later (two synchronizer flops and one edge register), the acknowledge drive follows a falling SCL by about four clocks and a stored word appears one clock after that. The bench holds each SCL phase for ten clocks, so it samples the acknowledge and read bits at mid-high of SCL and reads registers right after the acknowledge clock, well past each due cycle but before the next bus event. Rejected writes are checked by reading the register outputs after the transaction.

// File: rtl/modctl_pkg.sv
// Shared constants and types for the modulator control receiver.
package modctl_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int N_LSB  = 2;
    localparam int N_W    = 12;
    localparam int B_TYPE = 15;
    localparam int B_SO   = 13;
    localparam int B_OSC  = 6;
    localparam int B_ATT  = 5;
    localparam logic [WORD_W-1:0] CTRL_RST = 16'h8008;
    localparam logic [WORD_W-1:0] FREQ_RST = 16'h24F4;
    localparam logic [WORD_W-1:0] OPT1_RST = 16'h8000;
    localparam logic [WORD_W-1:0] OPT2_RST = 16'h8001;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_SKIP
    } eng_state_t;

    typedef enum logic [1:0] {CH_NONE, CH_CTRL, CH_OPT1, CH_OPT2} chain_t;
endpackage

// File: rtl/modctl_bus_sync.sv
// Multi-flop synchronizer for SCL and SDA.
// Assumes STAGES >= 2; idle bus level (1) is the reset value.
module modctl_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s
);
    logic [STAGES-1:0] scl_q, sda_q;

    // shift both lines through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];
endmodule

// File: rtl/modctl_byte_engine.sv
// Bit-level slave engine: START/STOP detection, address match,
// byte assembly, acknowledge drive and single status-byte read.
// Assumes synchronized inputs and SCL low for several clocks per bit.
module modctl_byte_engine
    import modctl_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_vld,
    output logic              txn_start,
    output logic              txn_stop
);
    localparam int CW = $clog2(MAX_BYTES + 1);
    localparam logic [CW-1:0] MAX_C = CW'(MAX_BYTES);

    eng_state_t        state;
    logic              scl_d, sda_d, rw;
    logic [BYTE_W-1:0] sh;
    logic [3:0]        cnt;
    logic [CW-1:0]     nbytes;
    logic              scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

    // remember previous line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // bus protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sh        <= '0;
            cnt       <= '0;
            nbytes    <= '0;
            rw        <= 1'b0;
            sda_oe    <= 1'b0;
            rx_byte   <= '0;
            rx_vld    <= 1'b0;
            txn_start <= 1'b0;
            txn_stop  <= 1'b0;
        end else begin
            rx_vld    <= 1'b0;
            txn_start <= start_c;
            txn_stop  <= stop_c;
            if (start_c) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (sh[7:1] == dev_addr) begin
                                rw     <= sh[0];
                                sda_oe <= 1'b1;
                                state  <= ST_AACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            if (rw) begin
                                sh     <= status_byte;
                                sda_oe <= ~status_byte[7];
                                cnt    <= 4'd1;
                                state  <= ST_RBYTE;
                            end else begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                nbytes <= '0;
                                state  <= ST_WBYTE;
                            end
                        end
                    end
                    ST_WBYTE: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (nbytes < MAX_C) begin
                                rx_byte <= sh;
                                rx_vld  <= 1'b1;
                                nbytes  <= nbytes + 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_WACK;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WBYTE;
                        end
                    end
                    ST_RBYTE: begin
                        if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_SKIP;
                            end else begin
                                sda_oe <= ~sh[6];
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/modctl_word_router.sv
// Pairs received bytes into words and routes them to the control,
// frequency and option registers with the write-protection rules.
// Assumes rx_vld never coincides with txn_bound.
module modctl_word_router
    import modctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_vld,
    input  logic              txn_bound,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] freq_q,
    output logic [WORD_W-1:0] opt1_q,
    output logic [WORD_W-1:0] opt2_q,
    output logic              standby
);
    logic              have_hi;
    logic [BYTE_W-1:0] hi_q;
    chain_t            chain;
    logic [WORD_W-1:0] word;
    logic              osc_off, n_zero, opt_ok;

    assign word    = {hi_q, rx_byte};
    assign standby = ctrl_q[B_SO] & ctrl_q[B_OSC] & ctrl_q[B_ATT];
    assign osc_off = ctrl_q[B_OSC];
    assign n_zero  = (word[N_LSB +: N_W] == '0);
    assign opt_ok  = ~standby & ~osc_off;

    // pairing, chain tracking and register commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_hi <= 1'b0;
            hi_q    <= '0;
            chain   <= CH_NONE;
            ctrl_q  <= CTRL_RST;
            freq_q  <= FREQ_RST;
            opt1_q  <= OPT1_RST;
            opt2_q  <= OPT2_RST;
        end else if (txn_bound) begin
            have_hi <= 1'b0;
            chain   <= CH_NONE;
        end else if (rx_vld) begin
            if (!have_hi) begin
                hi_q    <= rx_byte;
                have_hi <= 1'b1;
            end else begin
                have_hi <= 1'b0;
                if (!word[B_TYPE]) begin
                    chain <= CH_NONE;
                    if (!n_zero && !standby) freq_q <= word;
                end else begin
                    case (chain)
                        CH_CTRL: begin
                            if (opt_ok) opt1_q <= word;
                            chain <= CH_OPT1;
                        end
                        CH_OPT1: begin
                            if (opt_ok) opt2_q <= word;
                            chain <= CH_OPT2;
                        end
                        default: begin
                            ctrl_q <= word;
                            chain  <= CH_CTRL;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/modctl_i2c_slave.sv
// Top level: synchronizer, byte engine and word router for the
// modulator control receiver. Assumes clk >= 8x SCL frequency.
module modctl_i2c_slave
    import modctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_BYTES   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel,
    input  logic [2:0]        status_in,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] freq_word,
    output logic [WORD_W-1:0] opt1_word,
    output logic [WORD_W-1:0] opt2_word,
    output logic              standby
);
    logic              scl_s, sda_s;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_vld, txn_start, txn_stop;
    logic [6:0]        dev_addr;
    logic [BYTE_W-1:0] status_byte;

    assign dev_addr    = {5'b11001, addr_sel, 1'b1};
    assign status_byte = {5'b00000, status_in};

    modctl_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s)
    );

    modctl_byte_engine #(.MAX_BYTES(MAX_BYTES)) eng_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .dev_addr(dev_addr), .status_byte(status_byte), .sda_oe(sda_oe),
        .rx_byte(rx_byte), .rx_vld(rx_vld),
        .txn_start(txn_start), .txn_stop(txn_stop)
    );

    modctl_word_router rtr_i (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_vld(rx_vld),
        .txn_bound(txn_start | txn_stop),
        .ctrl_q(ctrl_word), .freq_q(freq_word),
        .opt1_q(opt1_word), .opt2_q(opt2_word), .standby(standby)
    );
endmodule

// File: rtl/modctl_i2c_checker.sv
// Protocol and register-protection properties for modctl_i2c_slave.
module modctl_i2c_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_s,
    input logic        sda_oe,
    input logic        standby,
    input logic [15:0] ctrl_word,
    input logic [15:0] freq_word,
    input logic [15:0] opt1_word,
    input logic [15:0] opt2_word
);
    assert_sda_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s);

    assert_word_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[15] && !freq_word[15] && opt1_word[15] && opt2_word[15]);

    assert_n_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        freq_word[13:2] != 12'd0);

    assert_standby_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> ($stable(freq_word) && $stable(opt1_word) && $stable(opt2_word)));

    assert_oscoff_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[6] |=> ($stable(opt1_word) && $stable(opt2_word)));
endmodule

bind modctl_i2c_slave modctl_i2c_checker chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .standby(standby), .ctrl_word(ctrl_word), .freq_word(freq_word),
    .opt1_word(opt1_word), .opt2_word(opt2_word)
);

// File: tb/modctl_i2c_slave_tb.sv
`timescale 1ns/1ps
module modctl_i2c_slave_tb_top;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic [2:0]  status_in = 3'b000;
    logic        sda_oe, standby;
    logic [15:0] ctrl_word, freq_word, opt1_word, opt2_word;
    logic        sda_line;
    logic        last_ack;
    int          checks = 0;
    int          errors = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    modctl_i2c_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .status_in(status_in),
        .ctrl_word(ctrl_word), .freq_word(freq_word),
        .opt1_word(opt1_word), .opt2_word(opt2_word), .standby(standby)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        last_ack = (sda_line == 1'b0);
        wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic rd_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1; wq();
            v[i] = sda_line;
            wq();
            scl_m = 1'b0; wq();
        end
        send_bit(1'b1);
    endtask

    task automatic wr_word(input logic [15:0] w);
        wr_byte(w[15:8]);
        wr_byte(w[7:0]);
    endtask

    task automatic begin_wr();
        bus_start();
        wr_byte(addr_sel ? 8'hCE : 8'hCA);
    endtask

    task automatic t_reset();
        chk("R11 ctrl reset", ctrl_word, 16'h8008);
        chk("R11 freq reset", freq_word, 16'h24F4);
        chk("R11 opt1 reset", opt1_word, 16'h8000);
        chk("R11 opt2 reset", opt2_word, 16'h8001);
        chk("R11 standby reset", {15'd0, standby}, 16'd0);
        chk("R11 sda released", {15'd0, sda_oe}, 16'd0);
    endtask

    task automatic t_address();
        bus_start(); wr_byte(8'hCE);
        chk("R1 foreign address no ack", {15'd0, last_ack}, 16'd0);
        wr_word(16'h8123);
        bus_stop();
        chk("R1 foreign address ctrl unchanged", ctrl_word, 16'h8008);
        bus_start(); wr_byte(8'hCA);
        chk("R1 own address ack", {15'd0, last_ack}, 16'd1);
        bus_stop();
    endtask

    task automatic t_ctrl_freq();
        begin_wr();
        wr_byte(8'h9A); wr_byte(8'h1C);
        chk("R6 ctrl visible after ack", ctrl_word, 16'h9A1C);
        wr_word(16'h4004);
        chk("R6 freq visible after ack", freq_word, 16'h4004);
        bus_stop();
        chk("R3 ctrl then freq ctrl", ctrl_word, 16'h9A1C);
        begin_wr(); wr_word(16'h1238); bus_stop();
        begin_wr(); wr_word(16'h8010); bus_stop();
        chk("R3 separate txn freq", freq_word, 16'h1238);
        chk("R3 separate txn ctrl", ctrl_word, 16'h8010);
    endtask

    task automatic t_options();
        begin_wr();
        wr_word(16'h8008); wr_word(16'h8123); wr_word(16'h8002);
        bus_stop();
        chk("R4 ctrl in chain", ctrl_word, 16'h8008);
        chk("R4 opt1 in chain", opt1_word, 16'h8123);
        chk("R4 opt2 in chain", opt2_word, 16'h8002);
        begin_wr(); wr_word(16'h8421); bus_stop();
        chk("R4 new txn goes to ctrl", ctrl_word, 16'h8421);
        chk("R4 new txn opt1 unchanged", opt1_word, 16'h8123);
    endtask

    task automatic t_odd();
        begin_wr(); wr_word(16'h0AB0); wr_byte(8'h80); bus_stop();
        chk("R2 odd freq stored", freq_word, 16'h0AB0);
        chk("R2 odd byte dropped ctrl", ctrl_word, 16'h8421);
        begin_wr(); wr_word(16'h0044); bus_stop();
        chk("R2 no carry of odd byte", freq_word, 16'h0044);
    endtask

    task automatic t_nine();
        begin_wr();
        wr_word(16'h8008); wr_word(16'h8111); wr_word(16'h8003); wr_word(16'h0100);
        chk("R5 eighth byte acked", {15'd0, last_ack}, 16'd1);
        wr_byte(8'hFF);
        chk("R5 ninth byte not acked", {15'd0, last_ack}, 16'd0);
        wr_byte(8'hFF);
        bus_stop();
        chk("R5 freq after nine", freq_word, 16'h0100);
        chk("R5 ctrl after nine", ctrl_word, 16'h8008);
        chk("R5 opt2 after nine", opt2_word, 16'h8003);
    endtask

    task automatic t_nzero();
        begin_wr(); wr_word(16'h4003); bus_stop();
        chk("R7 N zero rejected", freq_word, 16'h0100);
        begin_wr(); wr_word(16'h7FFF); bus_stop();
        chk("R7 N max stored", freq_word, 16'h7FFF);
    endtask

    task automatic t_standby();
        begin_wr(); wr_word(16'hA060); wr_word(16'h8777); bus_stop();
        chk("R8 standby set", {15'd0, standby}, 16'd1);
        chk("R8 opt1 rejected in standby", opt1_word, 16'h8111);
        begin_wr(); wr_word(16'h0200); bus_stop();
        chk("R8 freq rejected in standby", freq_word, 16'h7FFF);
        begin_wr(); wr_word(16'h8000); bus_stop();
        chk("R8 ctrl accepted in standby", ctrl_word, 16'h8000);
        chk("R8 standby cleared", {15'd0, standby}, 16'd0);
    endtask

    task automatic t_oscoff();
        begin_wr(); wr_word(16'h8040); wr_word(16'h8555); wr_word(16'h8666); bus_stop();
        chk("R9 opt1 rejected osc off", opt1_word, 16'h8111);
        chk("R9 opt2 rejected osc off", opt2_word, 16'h8003);
        begin_wr(); wr_word(16'h0204); bus_stop();
        chk("R9 freq accepted osc off", freq_word, 16'h0204);
        begin_wr(); wr_word(16'h8000); bus_stop();
    endtask

    task automatic t_read();
        logic [7:0] v;
        addr_sel = 1'b1;
        status_in = 3'b101;
        bus_start(); wr_byte(8'hCF);
        chk("R1 strap read address ack", {15'd0, last_ack}, 16'd1);
        rd_byte(v); bus_stop();
        chk("R10 status 101", {8'd0, v}, 16'h0005);
        status_in = 3'b010;
        bus_start(); wr_byte(8'hCF); rd_byte(v); bus_stop();
        chk("R10 status 010", {8'd0, v}, 16'h0002);
        begin_wr(); wr_word(16'h8200); bus_stop();
        chk("R1 strap write address", ctrl_word, 16'h8200);
        bus_start(); wr_byte(8'hCA);
        chk("R1 strap old address ignored", {15'd0, last_ack}, 16'd0);
        bus_stop();
        addr_sel = 1'b0;
    endtask

    task automatic t_abort();
        begin_wr();
        wr_byte(8'h80);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        wr_byte(8'hCA);
        bus_stop();
        chk("R12 aborted word not stored", ctrl_word, 16'h8200);
        begin_wr(); wr_word(16'h0010); bus_stop();
        chk("R12 pairing restarted", freq_word, 16'h0010);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        wq();
        t_reset();
        t_address();
        t_ctrl_freq();
        t_options();
        t_odd();
        t_nine();
        t_nzero();
        t_standby();
        t_oscoff();
        t_read();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule